// File: doc/BRIEF.md
# Carrier Detect Qualifier with Dropout Hysteresis

This block turns a raw per-sample in-band activity flag into a qualified, active-low carrier-detect output. The flag is raised by an upstream amplitude comparator whenever the band-pass output exceeds its threshold. Time is measured in ticks of a fixed number of master-clock cycles, nominally 1 ms. A tick counts as active when the flag was high in at least one cycle of its window.

The output goes low only after a run of consecutive active ticks of a set length, 20 ms by default. From then on it rides through short gaps in activity. It returns high only after a set number of consecutive inactive ticks, 10 by default. The asserted state also drives an enable for the downstream data recovery logic, which must ignore demodulator output while the carrier is not qualified. A power-down input forces the output inactive and restarts all timing from zero.

Top module: `cd_qual_top`

## Requirements
- R1: `carrierN` falls, at the clock edge that ends the tick, only when QUAL_TICKS consecutive ticks have been active.
- R2: Once `carrierN` is low, it stays low through any run of fewer than HOLD_TICKS consecutive inactive ticks.
- R3: `carrierN` returns high at the edge that ends the HOLD_TICKS-th consecutive inactive tick.
- R4: A tick ends every TICK_DIV clock cycles, and it is active if `bandActive` was high in any cycle of its window, including the last cycle.
- R5: `rxEnable` is high exactly when `carrierN` is low.
- R6: An inactive tick during qualification sets the qualification count back to zero.
- R7: While `powerDown` is high, `carrierN` is high from the next clock edge on, whatever `bandActive` does.
- R8: When `powerDown` falls, the tick divider and both counters start from zero, so a full qualification run is needed again.
- R9: After reset, `carrierN` is high and `rxEnable` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| powerDown | input | 1 | Forces the output inactive and clears all timing |
| bandActive | input | 1 | Per-sample flag: band-pass output above threshold |
| carrierN | output | 1 | Qualified carrier detect, active low |
| rxEnable | output | 1 | Enable for the data recovery logic, high while a carrier is held |

## Verification
Two events can fall in the same cycle: the tick that expires the release countdown, and a fresh activity sample in that same final cycle. The reload must win, so the output stays low. The bench provokes this by letting the countdown reach its last tick and then pulsing `bandActive` for the single cycle that closes that tick. It also pulses activity once per tick in mid-window, to show that one sample carries a whole tick. A behavioural reference model, compared on every clock, judges these cases together with directed samples taken at the exact tick edges.

// File: rtl/cd_qual_pkg.sv
package cd_qual_pkg;

  // Strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic clrAll;    // power-down: clear divider, accumulator and counters
    logic qualInc;   // advance the qualification count
    logic qualClr;   // restart the qualification count
    logic holdLoad;  // reload the release countdown
    logic holdDec;   // step the release countdown
  } cdq_cmd_t;

  // Status from the datapath back to the control FSM
  typedef struct packed {
    logic tick;        // last cycle of a tick window
    logic tickActive;  // this window saw activity (valid with tick)
    logic qualLast;    // one more active tick completes qualification
    logic qualZero;    // qualification count is zero
    logic holdLast;    // one more inactive tick expires the countdown
  } cdq_stat_t;

  typedef enum logic {
    CD_IDLE = 1'b0,
    CD_LOCK = 1'b1
  } cdq_state_e;

endpackage

// File: rtl/cd_qual_dp.sv
module cd_qual_dp
  import cd_qual_pkg::*;
#(
  parameter int TICK_DIV   = 3580,
  parameter int QUAL_TICKS = 20,
  parameter int HOLD_TICKS = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bandActive,
  input  cdq_cmd_t  cmd,
  output cdq_stat_t stat
);

  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int QW    = $clog2(QUAL_TICKS + 1);
  localparam int HW    = $clog2(HOLD_TICKS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(TICK_DIV - 1);
  localparam logic [QW-1:0]    QUAL_LAST = QW'(QUAL_TICKS - 1);
  localparam logic [HW-1:0]    HOLD_INIT = HW'(HOLD_TICKS);

  logic [DIV_W-1:0] divCnt;
  logic             actSeen;
  logic [QW-1:0]    qualCnt;
  logic [HW-1:0]    holdCnt;
  logic             tickNow;

  assign tickNow = (divCnt == DIV_LAST);

  // Tick divider and per-window activity accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      actSeen <= 1'b0;
    end else if (cmd.clrAll) begin
      divCnt  <= '0;
      actSeen <= 1'b0;
    end else if (tickNow) begin
      divCnt  <= '0;
      actSeen <= 1'b0;
    end else begin
      divCnt  <= divCnt + 1'b1;
      actSeen <= actSeen | bandActive;
    end
  end

  // Qualification run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
    end else if (cmd.clrAll || cmd.qualClr) begin
      qualCnt <= '0;
    end else if (cmd.qualInc) begin
      qualCnt <= qualCnt + 1'b1;
    end
  end

  // Release countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (cmd.clrAll) begin
      holdCnt <= '0;
    end else if (cmd.holdLoad) begin
      holdCnt <= HOLD_INIT;
    end else if (cmd.holdDec && (holdCnt != '0)) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    stat.tick       = tickNow;
    stat.tickActive = tickNow & (actSeen | bandActive);
    stat.qualLast   = (qualCnt == QUAL_LAST);
    stat.qualZero   = (qualCnt == '0);
    stat.holdLast   = (holdCnt <= HW'(1));
  end

endmodule

// File: rtl/cd_qual_ctrl.sv
module cd_qual_ctrl
  import cd_qual_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerDown,
  input  cdq_stat_t stat,
  output cdq_cmd_t  cmd,
  output logic      carrierOn
);

  cdq_state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CD_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    if (powerDown) begin
      cmd.clrAll = 1'b1;
      stateNxt   = CD_IDLE;
    end else if (stat.tick) begin
      unique case (state)
        CD_IDLE: begin
          if (!stat.tickActive) begin
            cmd.qualClr = 1'b1;
          end else if (stat.qualLast) begin
            cmd.qualClr  = 1'b1;
            cmd.holdLoad = 1'b1;
            stateNxt     = CD_LOCK;
          end else begin
            cmd.qualInc = 1'b1;
          end
        end
        CD_LOCK: begin
          if (stat.tickActive) begin
            cmd.holdLoad = 1'b1;
          end else if (stat.holdLast) begin
            cmd.qualClr = 1'b1;
            stateNxt    = CD_IDLE;
          end else begin
            cmd.holdDec = 1'b1;
          end
        end
        default: stateNxt = CD_IDLE;
      endcase
    end
  end

  assign carrierOn = (state == CD_LOCK);

endmodule

// File: rtl/cd_qual_top.sv
module cd_qual_top
  import cd_qual_pkg::*;
#(
  parameter int TICK_DIV   = 3580,
  parameter int QUAL_TICKS = 20,
  parameter int HOLD_TICKS = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerDown,
  input  logic bandActive,
  output logic carrierN,
  output logic rxEnable
);

  cdq_cmd_t  cmd;
  cdq_stat_t stat;
  logic      carrierOn;

  cd_qual_dp #(
    .TICK_DIV  (TICK_DIV),
    .QUAL_TICKS(QUAL_TICKS),
    .HOLD_TICKS(HOLD_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bandActive(bandActive),
    .cmd       (cmd),
    .stat      (stat)
  );

  cd_qual_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .powerDown(powerDown),
    .stat     (stat),
    .cmd      (cmd),
    .carrierOn(carrierOn)
  );

  assign carrierN = ~carrierOn;
  assign rxEnable = carrierOn;

endmodule

// File: rtl/cd_qual_chk.sv
module cd_qual_chk
  import cd_qual_pkg::*;
#(
  parameter int TICK_DIV = 3580
) (
  input logic      clk,
  input logic      rstN,
  input logic      powerDown,
  input logic      carrierN,
  input logic      rxEnable,
  input cdq_stat_t stat
);

  int gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= 0;
    end else if (powerDown || stat.tick) begin
      gapCnt <= 0;
    end else begin
      gapCnt <= gapCnt + 1;
    end
  end

  // R4: ticks are spaced exactly TICK_DIV cycles apart
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rstN || powerDown)
    stat.tick |-> (gapCnt == TICK_DIV - 1));

  // R1: assertion only at a tick completing an active run
  assert_qual_entry_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carrierN) |-> $past(stat.tick && stat.tickActive && stat.qualLast && !powerDown));

  // R2: an active tick while held keeps the carrier held
  assert_hold_ride_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!carrierN && stat.tick && stat.tickActive && !powerDown) |=> !carrierN);

  // R3: release only by power-down or at an expiring inactive tick
  assert_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carrierN) |-> ($past(powerDown) || $past(stat.tick && !stat.tickActive && stat.holdLast)));

  // R5: the enable follows the carrier state
  assert_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable != carrierN);

  // R6: an idle tick during qualification restarts the run
  assert_qual_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (carrierN && stat.tick && !stat.tickActive) |=> stat.qualZero);

  // R7: power-down holds the output inactive
  assert_pd_inactive_R7: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> carrierN);

  // R8: power-down clears the qualification run
  assert_pd_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> stat.qualZero);

endmodule

bind cd_qual_top cd_qual_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .powerDown(powerDown),
  .carrierN (carrierN),
  .rxEnable (rxEnable),
  .stat     (stat)
);

// File: tb/cd_qual_top_tb.sv
module cd_qual_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;
  localparam int QUAL_TICKS = 4;
  localparam int HOLD_TICKS = 3;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerDown = 1'b0;
  logic bandActive = 1'b0;
  logic carrierN;
  logic rxEnable;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference model state
  int  mPhase = 0;
  bit  mSeen  = 1'b0;
  int  mRun   = 0;
  int  mLeft  = 0;
  bit  mHeld  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cd_qual_top #(
    .TICK_DIV  (TICK_DIV),
    .QUAL_TICKS(QUAL_TICKS),
    .HOLD_TICKS(HOLD_TICKS)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .powerDown (powerDown),
    .bandActive(bandActive),
    .carrierN  (carrierN),
    .rxEnable  (rxEnable)
  );

  // Behavioural reference: advances once per clock
  always @(posedge clk) begin
    cycles++;
    if (!rstN || powerDown) begin
      mPhase = 0; mSeen = 0; mRun = 0; mLeft = 0; mHeld = 0;
    end else begin
      bit windowHit;
      windowHit = mSeen || bandActive;
      if (mPhase == TICK_DIV - 1) begin
        if (!mHeld) begin
          mRun = windowHit ? mRun + 1 : 0;
          if (mRun == QUAL_TICKS) begin
            mHeld = 1; mRun = 0; mLeft = HOLD_TICKS;
          end
        end else if (windowHit) begin
          mLeft = HOLD_TICKS;
        end else begin
          mLeft = mLeft - 1;
          if (mLeft <= 0) mHeld = 0;
        end
        mPhase = 0; mSeen = 0;
      end else begin
        mPhase++;
        mSeen = windowHit;
      end
    end
  end

  // Every-cycle comparison with the model (R1 R2 R3 R4 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (carrierN !== !mHeld || rxEnable !== mHeld) begin
        errors++;
        $display("FAIL model R1/R3 cycle %0d: carrierN=%b rxEnable=%b expected carrierN=%b rxEnable=%b",
                 cycles, carrierN, rxEnable, !mHeld, mHeld);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_cd(input string tag, input logic expN);
    checks++;
    if (carrierN !== expN || rxEnable !== !expN) begin
      errors++;
      $display("FAIL %s: carrierN=%b rxEnable=%b expected carrierN=%b rxEnable=%b",
               tag, carrierN, rxEnable, expN, !expN);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual cycles %0d expected below %0d", cycles, WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    expect_cd("R9 reset state", 1'b1);

    // Align timing with a short power-down
    powerDown = 1'b1;
    step(2);
    powerDown = 1'b0;

    // R1: continuous activity qualifies at tick QUAL_TICKS (edge 32)
    bandActive = 1'b1;
    step(31);
    expect_cd("R1 not yet qualified", 1'b1);
    step(1);
    expect_cd("R1 qualified", 1'b0);
    expect_cd("R5 enable follows carrier", 1'b0);

    // R2: two inactive ticks are ridden through
    bandActive = 1'b0;
    step(16);
    expect_cd("R2 dropout ridden", 1'b0);
    bandActive = 1'b1;
    step(8);
    expect_cd("R2 reload after dropout", 1'b0);

    // R3: release on the third inactive tick (edge 80)
    bandActive = 1'b0;
    step(23);
    expect_cd("R3 before release", 1'b0);
    step(1);
    expect_cd("R3 released", 1'b1);

    // R6: an inactive tick after three active ones restarts the run
    bandActive = 1'b1;
    step(24);
    bandActive = 1'b0;
    step(8);
    bandActive = 1'b1;
    step(31);
    expect_cd("R6 run restarted", 1'b1);
    step(1);
    expect_cd("R6 qualified after full run", 1'b0);

    // R4: one mid-window sample per tick keeps the carrier held
    bandActive = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(3);
      bandActive = 1'b1;
      step(1);
      bandActive = 1'b0;
      step(4);
    end
    expect_cd("R4 single sample per tick", 1'b0);

    // R4/R2: activity only in the expiring tick's final cycle reloads
    step(16);
    step(7);
    bandActive = 1'b1;
    step(1);
    bandActive = 1'b0;
    expect_cd("R4 last-cycle sample beats expiry", 1'b0);
    step(24);
    expect_cd("R3 release after final pulse", 1'b1);

    // R7: power-down forces the output inactive and holds it
    bandActive = 1'b1;
    step(32);
    expect_cd("R1 requalified", 1'b0);
    powerDown = 1'b1;
    step(1);
    expect_cd("R7 forced inactive", 1'b1);
    step(40);
    expect_cd("R7 held inactive with activity", 1'b1);

    // R8: leaving power-down needs a full run
    powerDown = 1'b0;
    step(31);
    expect_cd("R8 full run after power-down", 1'b1);
    step(1);
    expect_cd("R8 qualified after power-down", 1'b0);

    // R8: a partial run is discarded by a one-cycle power-down
    powerDown = 1'b1;
    step(2);
    powerDown = 1'b0;
    step(24);
    powerDown = 1'b1;
    step(1);
    powerDown = 1'b0;
    step(31);
    expect_cd("R8 partial run discarded", 1'b1);
    step(1);
    expect_cd("R8 qualified after discard", 1'b0);

    step(4);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule